// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 63-bit free-running tick count next to a 63-bit compare value. The top bit of each 64-bit register word is a disable flag. The block holds one disable flag, and a write to either register updates it. When the running count equals an armed compare value while the flag is clear, the block emits a one-cycle set pulse on one bit of a software-interrupt vector. A parameter chooses that bit: the tick-match bit or the system-tick-match bit.

Software reaches the block through a single-cycle register port. The port has a select (count or compare), a write enable, 64-bit write data and 64-bit read data. The read data always shows the count word, and its top bit is the disable flag. The counter advances once for each clock cycle in which `tick_en` is high. Tie `tick_en` high to count every clock, or drive it from a prescaler strobe.

A compare value of zero is never armed. A match fires only once. It is armed again by rewriting the compare register, or by the counter wrapping from all ones to zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, `reg_rdata` is zero (count zero, flag clear), the compare value is zero, and no pulse appears on `softint_set`.
- R2: A write with `reg_sel`=0 (count) loads `reg_wdata[62:0]` into the counter and `reg_wdata[63]` into the disable flag. `reg_rdata` shows {flag, count} whatever the value of `reg_sel`.
- R3: In a cycle with `tick_en` high and no count write, the count rises by one. With `tick_en` low and no write, the count holds.
- R4: The count wraps from all ones (2^63-1) to zero, and the disable flag is unchanged.
- R5: A write with `reg_sel`=1 (compare) loads `reg_wdata[62:0]` as the compare value and `reg_wdata[63]` into the shared disable flag. The new flag value shows in `reg_rdata[63]`.
- R6: A match occurs in a cycle where the count equals a nonzero compare value, the flag is clear and the compare is armed. In the next cycle, `softint_set` is high for one cycle at bit `TICK_BIT` (default 0), or at bit `STICK_BIT` (default 16) when `SEL_SYSTEM`=1. All other bits are zero.
- R7: A match fires once. While the count stays equal to the compare value, no further pulse follows.
- R8: A fired compare is armed again by a compare write, or by the counter wrapping to zero.
- R9: A compare value of zero never produces a pulse. Writing zero cancels a match that was armed but had not yet been reached.
- R10: While the disable flag is set, no pulse occurs and the match is not consumed. Clearing the flag with a compare write lets a standing match fire.
- R11: A cycle that carries any register write produces no match, even if the count equals the compare value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count strobe: the counter advances in cycles where this is high |
| reg_sel | input | 1 | Register select: 0 count, 1 compare |
| reg_we | input | 1 | Write enable, single cycle |
| reg_wdata | input | 64 | Write word: bit 63 disable flag, bits 62:0 value |
| reg_rdata | output | 64 | Count word: bit 63 disable flag, bits 62:0 count |
| softint_set | output | SOFTINT_W | One-cycle set pulse on the configured interrupt bit |

## Verification
The bound checker watches every cycle for the following:
- the pulse lands only on the configured bit;
- a pulse never repeats in the next cycle;
- a pulse never follows a cycle with the flag set or with a write;
- the count steps, holds and loads as written.

Other behaviours depend on history and can only be shown by the bench scenarios. These are:
- firing exactly once while a match persists;
- re-arming through a compare rewrite or a wrap;
- a zero compare cancelling a pending match;
- a standing match firing once the flag is cleared;
- a match hidden under a write cycle.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int TICK_REG_W = 64;
    localparam int TICK_VAL_W = TICK_REG_W - 1;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_LIMIT = 1'b1
    } tick_sel_e;

    typedef struct packed {
        logic                  dis;
        logic [TICK_VAL_W-1:0] val;
    } tick_word_t;

    function automatic tick_word_t split_word(input logic [TICK_REG_W-1:0] w);
        tick_word_t t;
        t.dis = w[TICK_REG_W-1];
        t.val = w[TICK_VAL_W-1:0];
        return t;
    endfunction

endpackage

// File: rtl/tick_count_reg.sv
module tick_count_reg
    import tick_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  cnt_we,
    input  logic                  any_we,
    input  tick_word_t            wr_word,
    output logic [TICK_VAL_W-1:0] cnt,
    output logic                  dis,
    output logic                  wrap
);

    localparam logic [TICK_VAL_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dis <= 1'b0;
        end else begin
            if (any_we) begin
                dis <= wr_word.dis;
            end
            if (cnt_we) begin
                cnt <= wr_word.val;
            end else if (tick_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign wrap = tick_en && !cnt_we && (cnt == CNT_MAX);

endmodule

// File: rtl/tick_match_unit.sv
module tick_match_unit
    import tick_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lim_we,
    input  logic                  any_we,
    input  tick_word_t            wr_word,
    input  logic [TICK_VAL_W-1:0] cnt,
    input  logic                  dis,
    input  logic                  wrap,
    output logic                  hit
);

    logic [TICK_VAL_W-1:0] lim;
    logic                  fired;
    logic                  armed;

    assign armed = (lim != '0) && !fired;
    assign hit   = armed && !dis && !any_we && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim   <= '0;
            fired <= 1'b0;
        end else if (lim_we) begin
            lim   <= wr_word.val;
            fired <= 1'b0;
        end else if (hit) begin
            fired <= 1'b1;
        end else if (wrap) begin
            fired <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_pulse_out.sv
module tick_pulse_out #(
    parameter int SOFTINT_W = 17,
    parameter int BIT_SEL   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit,
    output logic [SOFTINT_W-1:0] pulse
);

    for (genvar i = 0; i < SOFTINT_W; i++) begin : g_bit
        if (i == BIT_SEL) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) pulse[i] <= 1'b0;
                else     pulse[i] <= hit;
            end
        end else begin : g_tied
            assign pulse[i] = 1'b0;
        end
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int SOFTINT_W  = 17,
    parameter int TICK_BIT   = 0,
    parameter int STICK_BIT  = 16,
    parameter bit SEL_SYSTEM = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  reg_sel,
    input  logic                  reg_we,
    input  logic [TICK_REG_W-1:0] reg_wdata,
    output logic [TICK_REG_W-1:0] reg_rdata,
    output logic [SOFTINT_W-1:0]  softint_set
);

    localparam int PULSE_BIT = SEL_SYSTEM ? STICK_BIT : TICK_BIT;

    tick_word_t            wr_word;
    logic                  cnt_we;
    logic                  lim_we;
    logic [TICK_VAL_W-1:0] cnt;
    logic                  dis;
    logic                  wrap;
    logic                  hit;

    assign wr_word = split_word(reg_wdata);
    assign cnt_we  = reg_we && (tick_sel_e'(reg_sel) == SEL_COUNT);
    assign lim_we  = reg_we && (tick_sel_e'(reg_sel) == SEL_LIMIT);

    tick_count_reg u_count (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_we  (cnt_we),
        .any_we  (reg_we),
        .wr_word (wr_word),
        .cnt     (cnt),
        .dis     (dis),
        .wrap    (wrap)
    );

    tick_match_unit u_match (
        .clk     (clk),
        .rst     (rst),
        .lim_we  (lim_we),
        .any_we  (reg_we),
        .wr_word (wr_word),
        .cnt     (cnt),
        .dis     (dis),
        .wrap    (wrap),
        .hit     (hit)
    );

    tick_pulse_out #(
        .SOFTINT_W (SOFTINT_W),
        .BIT_SEL   (PULSE_BIT)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .pulse (softint_set)
    );

    assign reg_rdata = {dis, cnt};

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int SOFTINT_W = 17,
    parameter int EXP_BIT   = 0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_en,
    input logic                 reg_sel,
    input logic                 reg_we,
    input logic [63:0]          reg_wdata,
    input logic [63:0]          reg_rdata,
    input logic [SOFTINT_W-1:0] softint_set
);

    localparam logic [SOFTINT_W-1:0] EXP_MASK = SOFTINT_W'(1) << EXP_BIT;

    // R6
    pulse_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (softint_set != '0) |-> (softint_set == EXP_MASK));

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        (softint_set != '0) |=> (softint_set == '0));

    // R10
    pulse_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (softint_set != '0) |-> !$past(reg_rdata[63]));

    // R11
    pulse_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (softint_set != '0) |-> !$past(reg_we));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && tick_en) |=> (reg_rdata[62:0] == 63'($past(reg_rdata[62:0]) + 63'd1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !tick_en) |=> $stable(reg_rdata));

    // R2
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel) |=> (reg_rdata == $past(reg_wdata)));

endmodule

bind tick_timer tick_timer_chk #(
    .SOFTINT_W (SOFTINT_W),
    .EXP_BIT   (PULSE_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .reg_sel     (reg_sel),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .softint_set (softint_set)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;

    localparam int SW = 17;
    localparam logic [62:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic          reg_we = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic [SW-1:0] softint_set;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [SW-1:0] last_bits = '0;
    logic [63:0]   last_rd = '0;

    tick_timer i_tick_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .reg_sel     (reg_sel),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .softint_set (softint_set)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        #2;
        if (!rst && softint_set != '0) begin
            pulses++;
            last_bits = softint_set;
            last_rd = reg_rdata;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [63:0] data);
        @(negedge clk);
        reg_sel = sel;
        reg_we = 1'b1;
        reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(3);
        check("R1 rdata", reg_rdata, 64'd0);
        check("R1 pulses", 64'(pulses), 64'd0);
    endtask

    task automatic t_count_rw;
        wr(1'b0, {1'b1, 63'd5});
        reg_sel = 1'b1;
        idle(1);
        check("R2 load with flag", reg_rdata, {1'b1, 63'd5});
        wr(1'b0, {1'b0, 63'h1234_5678_9ABC});
        check("R2 load", reg_rdata, {1'b0, 63'h1234_5678_9ABC});
    endtask

    task automatic t_increment;
        wr(1'b0, 64'd100);
        tick_en = 1'b1;
        idle(7);
        tick_en = 1'b0;
        check("R3 count steps", reg_rdata, 64'd107);
        idle(4);
        check("R3 count holds", reg_rdata, 64'd107);
    endtask

    task automatic t_prescale;
        wr(1'b0, 64'd0);
        for (int i = 0; i < 12; i++) begin
            tick_en = (i % 4 == 0);
            @(negedge clk);
        end
        tick_en = 1'b0;
        check("R3 strobe count", reg_rdata, 64'd3);
    endtask

    task automatic t_match;
        int p0;
        p0 = pulses;
        wr(1'b0, 64'd10);
        wr(1'b1, 64'd20);
        tick_en = 1'b1;
        idle(15);
        tick_en = 1'b0;
        idle(2);
        check("R6 one pulse", 64'(pulses - p0), 64'd1);
        check("R6 pulse bit", 64'(last_bits), 64'(17'd1));
        check("R6 pulse timing", last_rd, 64'd21);
    endtask

    task automatic t_once_rearm;
        int p0;
        p0 = pulses;
        wr(1'b1, 64'd40);
        wr(1'b0, 64'd40);
        idle(10);
        check("R7 fires once", 64'(pulses - p0), 64'd1);
        wr(1'b1, 64'd40);
        idle(5);
        check("R8 limit rewrite rearms", 64'(pulses - p0), 64'd2);
    endtask

    task automatic t_disable;
        int p0;
        p0 = pulses;
        wr(1'b1, {1'b1, 63'd50});
        wr(1'b0, {1'b1, 63'd50});
        idle(6);
        check("R10 no pulse while disabled", 64'(pulses - p0), 64'd0);
        check("R5 flag visible", reg_rdata, {1'b1, 63'd50});
        wr(1'b1, {1'b0, 63'd50});
        idle(3);
        check("R10 standing match fires", 64'(pulses - p0), 64'd1);
        check("R5 flag cleared by limit write", reg_rdata, {1'b0, 63'd50});
    endtask

    task automatic t_zero;
        int p0;
        p0 = pulses;
        wr(1'b1, 64'd0);
        wr(1'b0, 64'd0);
        idle(5);
        check("R9 zero limit silent", 64'(pulses - p0), 64'd0);
        wr(1'b1, 64'd30);
        wr(1'b0, 64'd25);
        wr(1'b1, 64'd0);
        tick_en = 1'b1;
        idle(10);
        tick_en = 1'b0;
        idle(2);
        check("R9 zero cancels pending", 64'(pulses - p0), 64'd0);
    endtask

    task automatic t_wrap;
        int p0;
        p0 = pulses;
        wr(1'b0, {1'b1, MAXV});
        tick_en = 1'b1;
        idle(1);
        tick_en = 1'b0;
        check("R4 wrap keeps flag", reg_rdata, {1'b1, 63'd0});
        wr(1'b1, 64'd3);
        wr(1'b0, {1'b0, MAXV - 63'd1});
        tick_en = 1'b1;
        idle(8);
        tick_en = 1'b0;
        idle(2);
        check("R8 first pass fires", 64'(pulses - p0), 64'd1);
        wr(1'b0, {1'b0, MAXV - 63'd1});
        tick_en = 1'b1;
        idle(8);
        tick_en = 1'b0;
        idle(2);
        check("R8 wrap rearms", 64'(pulses - p0), 64'd2);
    endtask

    task automatic t_write_mask;
        int p0;
        p0 = pulses;
        wr(1'b0, 64'd79);
        wr(1'b1, 64'd80);
        tick_en = 1'b1;
        @(negedge clk);
        reg_sel = 1'b1;
        reg_we = 1'b1;
        reg_wdata = 64'd80;
        @(negedge clk);
        reg_we = 1'b0;
        tick_en = 1'b0;
        idle(4);
        check("R11 write cycle masks match", 64'(pulses - p0), 64'd0);
        check("R11 count moved past", reg_rdata, 64'd81);
    endtask

    initial begin
        t_reset();
        t_count_rw();
        t_increment();
        t_prescale();
        t_match();
        t_once_rearm();
        t_disable();
        t_zero();
        t_wrap();
        t_write_mask();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end

endmodule